// File: doc/BRIEF.md
# Memory Throughput Test Sequencer

This block generates traffic for timing a memory controller. After a start pulse it issues a fixed, counted run of single-word accesses over a strobe/acknowledge handshake. The total run time can then be measured from outside. A free-running operation index gives each access its word address and its write data. A mode captured at start decides whether the run is all reads, all writes, or a fixed mix in which one access in four is a write.

Each access keeps the strobe high until the controller acknowledges it. The sequencer then spends exactly one idle cycle before it raises the strobe for the next index. After the final acknowledged access, a done flag rises and stays high. No further strobe is issued until reset. The run length is two to the power of a parameter, 27 by default. Every access moves one full 32-bit word.

Top module: `memtest_seq`

## Requirements
- R1: While reset is held and directly after it, `stb` is 0 and `done` is 0.
- R2: With no `start` pulse the block stays idle with `stb` at 0. A `start` seen at a clock edge while idle makes `stb` high in the very next cycle, carrying operation index 0.
- R3: Once `stb` is high it stays high until a cycle with `ack` high. While it waits, `addr`, `we` and `wrData` hold their values.
- R4: A cycle with `stb` and `ack` both high is always followed by exactly one cycle with `stb` low, and then by the next access when operations remain.
- R5: Accesses carry operation indices 0, 1, 2, … in order, each exactly once. `addr` is the index, zero-extended or truncated to `ADDR_W` bits.
- R6: `wrData` equals the operation index, zero-extended to `DATA_W` bits, XOR the parameter `SEED` (default 32'h5A5A_0000).
- R7: The mode code is 2'b00 for reads only (`we`=0) and 2'b01 for writes only (`we`=1). Code 2'b10 is the mix: `we`=1 exactly when the low `MIX_BITS` (default 2) bits of the index are all ones, which gives 3 reads per write. Code 2'b11 behaves as reads only.
- R8: A run is exactly 2^`RUN_LOG2` accesses. In the cycle after the last acknowledged access, `done` is 1. It then stays 1, and `stb` stays 0 until reset, even if `start` is pulsed again.
- R9: `mode` is sampled only with the accepted `start`. Changing `mode` or pulsing `start` during a run does not alter the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| mode | input | 2 | Read/write pattern, captured with start |
| ack | input | 1 | Controller acknowledges the current access |
| stb | output | 1 | Access request, held until ack |
| we | output | 1 | 1 = write, 0 = read |
| addr | output | ADDR_W | Word address of the current access |
| wrData | output | DATA_W | Data for write accesses |
| done | output | 1 | Run finished (sticky until reset) |

## Verification
The bench serves the handshake with several acknowledge latencies, including same-cycle acknowledge. A design that skipped the recovery cycle, or that added a second one, would show the wrong idle count between accesses. The first access is expected with no idle cycle after start, so an extra pipeline stage would be caught. Each run pulses `start` and flips `mode` mid-run, so a design that re-sampled the mode would flip `we` on later accesses. The end of the run is checked in the cycle after the last acknowledge, then again after a further start pulse: an off-by-one counter or a restart after done would show up as a stray strobe or a late done.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_MIX   = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ACCESS,
    S_GAP,
    S_DONE
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;
    logic incCnt;
    logic loadMode;
  } dp_ctrl_t;

endpackage

// File: rtl/mt_datapath.sv
module mt_datapath
  import memtest_pkg::*;
#(
  parameter int RUN_LOG2 = 27,
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int MIX_BITS = 2,
  parameter logic [DATA_W-1:0] SEED = 32'h5A5A_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctrl,
  input  logic [1:0]        modeIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrData,
  output logic              we,
  output logic              lastOp
);

  localparam int CNT_W = RUN_LOG2;

  logic [CNT_W-1:0] opCnt;
  mode_e            modeReg;
  logic             mixWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opCnt   <= '0;
      modeReg <= MODE_READ;
    end else begin
      if (ctrl.clearCnt)    opCnt <= '0;
      else if (ctrl.incCnt) opCnt <= opCnt + 1'b1;
      if (ctrl.loadMode)    modeReg <= mode_e'(modeIn);
    end
  end

  assign lastOp   = &opCnt;
  assign mixWrite = &opCnt[MIX_BITS-1:0];

  always_comb begin
    unique case (modeReg)
      MODE_WRITE: we = 1'b1;
      MODE_MIX:   we = mixWrite;
      default:    we = 1'b0;
    endcase
  end

  generate
    if (ADDR_W <= CNT_W) begin : g_addrTrunc
      assign addr = opCnt[ADDR_W-1:0];
    end else begin : g_addrExt
      assign addr = {{(ADDR_W-CNT_W){1'b0}}, opCnt};
    end

    if (DATA_W > CNT_W) begin : g_dataExt
      assign wrData = {{(DATA_W-CNT_W){1'b0}}, opCnt} ^ SEED;
    end else begin : g_dataTrunc
      assign wrData = opCnt[DATA_W-1:0] ^ SEED;
    end
  endgenerate

endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import memtest_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     ack,
  input  logic     lastOp,
  output dp_ctrl_t ctrl,
  output logic     stb,
  output logic     done
);

  seq_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:   if (start) stateNext = S_ACCESS;
      S_ACCESS: if (ack)   stateNext = lastOp ? S_DONE : S_GAP;
      S_GAP:    stateNext = S_ACCESS;
      S_DONE:   stateNext = S_DONE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    ctrl.loadMode = (state == S_IDLE) && start;
    ctrl.clearCnt = (state == S_IDLE) && start;
    ctrl.incCnt   = (state == S_GAP);
  end

  assign stb  = (state == S_ACCESS);
  assign done = (state == S_DONE);

  AST_STB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stb && !ack |=> stb); // R3
  AST_ONE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    stb && ack |=> !stb); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !stb); // R8

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int RUN_LOG2 = 27,
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int MIX_BITS = 2,
  parameter logic [DATA_W-1:0] SEED = 32'h5A5A_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              ack,
  output logic              stb,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrData,
  output logic              done
);

  dp_ctrl_t ctrl;
  logic     lastOp;

  mt_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .ack    (ack),
    .lastOp (lastOp),
    .ctrl   (ctrl),
    .stb    (stb),
    .done   (done)
  );

  mt_datapath #(
    .RUN_LOG2 (RUN_LOG2),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MIX_BITS (MIX_BITS),
    .SEED     (SEED)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .modeIn (mode),
    .addr   (addr),
    .wrData (wrData),
    .we     (we),
    .lastOp (lastOp)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stb && !ack |=> $stable(addr) && $stable(wrData)); // R3
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stb && !ack |=> $stable(we)); // R3

endmodule

// File: tb/memtest_seq_tb.sv
module memtest_seq_tb;

  localparam int RUN_LOG2 = 4;
  localparam int NOPS     = 1 << RUN_LOG2;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam logic [31:0] SEED = 32'h5A5A_0000;

  // each vector: {mode[1:0], ackDelay[3:0]}
  localparam logic [5:0] VEC [0:5] = '{
    {2'b00, 4'd0}, {2'b01, 4'd0}, {2'b10, 4'd0},
    {2'b11, 4'd1}, {2'b10, 4'd3}, {2'b00, 4'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ack = 1'b0;
  logic stb, we, done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wrData;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  memtest_seq #(
    .RUN_LOG2 (RUN_LOG2),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MIX_BITS (2),
    .SEED     (SEED)
  ) u_dut (
    .clk (clk), .rstN (rstN), .start (start), .mode (mode), .ack (ack),
    .stb (stb), .we (we), .addr (addr), .wrData (wrData), .done (done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; ack = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    check(!stb && !done, "R1", {stb, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!stb && !done, "R1", {stb, done}, 0);
  endtask

  task automatic runSeq(input logic [1:0] md, input int dly);
    doReset();
    mode = md;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < NOPS; i++) begin
      int idle = 0;
      logic expWe;
      while (!stb && idle < 40) begin
        idle++;
        @(negedge clk);
      end
      if (i == 0) check(idle == 0, "R2", idle, 0);
      else        check(idle == 1, "R4", idle, 1);
      expWe = (md == 2'b01) ? 1'b1 : (md == 2'b10) ? ((i & 3) == 3) : 1'b0;
      check(addr == ADDR_W'(i), "R5", addr, i);
      check(wrData == (DATA_W'(i) ^ SEED), "R6", wrData, DATA_W'(i) ^ SEED);
      check(we == expWe, "R7", we, expWe);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        check(stb && addr == ADDR_W'(i) && we == expWe, "R3",
              {stb, we, addr}, {1'b1, expWe, ADDR_W'(i)});
      end
      if (i == 5) begin  // R9: disturb mode and start mid-run
        mode = ~md;
        start = 1'b1;
      end
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      start = 1'b0;
      if (i == NOPS - 1) check(done && !stb, "R8", {done, stb}, 2'b10);
      else               check(!done && !stb, "R4", {done, stb}, 2'b00);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(done && !stb, "R8", {done, stb}, 2'b10);
      @(negedge clk);
    end
  endtask

  initial begin
    doReset();
    // R2: no start -> stays idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!stb && !done, "R2", {stb, done}, 0);
    end
    for (int v = 0; v < 6; v++) begin
      runSeq(VEC[v][5:4], int'(VEC[v][3:0]));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule